// File: doc/BRIEF.md
# Patterned Line Walk Engine

The engine traces a straight line between two points on a bit-plane screen. It turns each visible dot into a byte address and a per-byte write mask. It then hands one request per touched byte to a downstream logic unit, which performs the read-modify-write. The engine does not touch plane memory itself.

The start point, end point, dash pattern and address offset are written into byte-wide registers. The screen width (in bytes), the height and the line-count mode are static inputs. A `start` pulse launches the walk. `busy` stays high until the last byte has been accepted. After a long line, `busy` stays high for a further hold time that models the memory time of the burst.

Stepping runs along the longer axis. The shorter axis advances from a fixed-point accumulator whose slope comes from a sequential divider. A 16-bit dash pattern rotates once per drawn dot. The pattern keeps its rotated value between lines, so a dash sequence carries on across joined segments.

Top module: `line_walk_engine`

## Requirements
- R1: Register writes use `wr_sel` codes as follows: 0/1 offset high/low byte, 2/3 pattern high/low, 4/5 start X high/low, 6/7 start Y high/low, 8/9 end X high/low, 10/11 end Y high/low. Codes 12 to 15 write nothing. Register writes and `start` pulses are ignored while `busy` is high.
- R2: The byte address of a dot is y*`scr_wbytes` + floor(x/8) + 2*offset. It is truncated to 15 bits when `mode400` is 1 and to 14 bits (bit 14 zero) otherwise.
- R3: A dot is skipped if x<0 or y<0 (16-bit two's complement), if x >= 8*`scr_wbytes`, or if y >= `scr_height`. Every dot is skipped while `draw_en` is 0. A skipped dot leaves the pattern and the mask untouched.
- R4: For each drawn dot, if pattern bit 15 is 1, mask bit (7 - x mod 8) is cleared; a 0 bit in `op_mask` marks a pixel to write. After each drawn dot the pattern rotates left by one place. The rotated value is kept for the next line.
- R5: When a drawn dot's address differs from the previous drawn dot's address, a request for the previous address with its mask is issued. The mask then restarts at 0xFF before the new dot is applied.
- R6: After the final dot, the pending byte is issued. A line with no drawn dot issues no request.
- R7: The major axis is X when |dx| >= |dy|, otherwise Y. The slope is floor((|minor|+1)*1024/|major|). It is added each major step; when the sum reaches 1024, 1024 is removed and the minor coordinate steps, unless it has already reached its end. Dots run from start to end inclusive, and a zero-length line yields one dot.
- R8: If N bytes were issued and N > 8, `busy` stays high for floor(N*CYC_PER_US/16) cycles after the last accepted request. Otherwise it falls on the cycle after that acceptance.
- R9: `op_valid` keeps `op_addr` and `op_mask` unchanged until a cycle with `op_ready` high, and is only high while `busy` is high.
- R10: After reset, `busy` and `op_valid` are low and all registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register byte write strobe |
| wr_sel | input | 4 | Register byte select |
| wr_data | input | 8 | Register write data |
| start | input | 1 | Launch a line walk |
| draw_en | input | 1 | Drawing enable; no dot is drawn when low |
| mode400 | input | 1 | 1 = 15-bit addresses, 0 = 14-bit |
| scr_wbytes | input | 8 | Screen width in bytes |
| scr_height | input | 16 | Screen height in lines |
| busy | output | 1 | Walk or hold time in progress |
| op_valid | output | 1 | Byte request valid |
| op_addr | output | 15 | Byte request address |
| op_mask | output | 8 | Byte write mask, 0 = write pixel |
| op_ready | input | 1 | Logic unit accepts the request |

## Verification
The assertions assume that `draw_en`, `mode400`, `scr_wbytes` and `scr_height` stay constant while `busy` is high. They also assume that the logic unit may hold `op_ready` low for any number of cycles. The bench changes the screen inputs only between lines and stalls `op_ready` at random. It keeps coordinates within a few dozen pixels around a small screen, so that clipping on every edge occurs often. Offsets are chosen so that the 14-bit address wrap is reached.

// File: rtl/lwe_pkg.sv
package lwe_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int SEL_W  = 4;
  localparam int NREG   = 6;

  localparam int IDX_OFF = 0;
  localparam int IDX_PAT = 1;
  localparam int IDX_XS  = 2;
  localparam int IDX_YS  = 3;
  localparam int IDX_XE  = 4;
  localparam int IDX_YE  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV,
    ST_DOT,
    ST_WAIT,
    ST_LAST,
    ST_WLAST
  } lwe_state_e;
endpackage

// File: rtl/lwe_regs.sv
module lwe_regs
  import lwe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              lock,
  input  logic              pat_upd,
  input  logic [WORD_W-1:0] pat_new,
  output logic [WORD_W-1:0] words [NREG]
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NREG; w++) words[w] <= '0;
    end else begin
      for (int w = 0; w < NREG; w++) begin
        if (w == IDX_PAT && pat_upd) begin
          words[w] <= pat_new;
        end else if (wr_en && !lock && wr_sel[SEL_W-1:1] == (SEL_W-1)'(w)) begin
          if (wr_sel[0]) words[w][BYTE_W-1:0] <= wr_data;
          else           words[w][WORD_W-1:BYTE_W] <= wr_data;
        end
      end
    end
  end
endmodule

// File: rtl/lwe_div.sv
module lwe_div #(
  parameter int NUM_W = 27,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W:0] rem;
  logic [CW-1:0]  cnt;
  logic [DEN_W:0] trial;

  assign trial = {rem[DEN_W-1:0], quo[NUM_W-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      quo  <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        quo <= num;
        rem <= '0;
        cnt <= CW'(NUM_W);
      end else if (cnt != '0) begin
        if (trial >= {1'b0, den}) begin
          rem <= trial - {1'b0, den};
          quo <= {quo[NUM_W-2:0], 1'b1};
        end else begin
          rem <= trial;
          quo <= {quo[NUM_W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lwe_hold.sv
module lwe_hold #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] val,
  output logic             active
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/line_walk_engine.sv
module line_walk_engine
  import lwe_pkg::*;
#(
  parameter int WB_W       = 8,
  parameter int ADDR_W     = 15,
  parameter int FRAC_W     = 10,
  parameter int CNT_W      = 16,
  parameter int CYC_PER_US = 16,
  parameter int BURST_LIM  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              start,
  input  logic              draw_en,
  input  logic              mode400,
  input  logic [WB_W-1:0]   scr_wbytes,
  input  logic [WORD_W-1:0] scr_height,
  output logic              busy,
  output logic              op_valid,
  output logic [ADDR_W-1:0] op_addr,
  output logic [BYTE_W-1:0] op_mask,
  input  logic              op_ready
);
  localparam int DIFF_W = WORD_W + 1;
  localparam int NUM_W  = DIFF_W + FRAC_W;
  localparam int ACC_W  = NUM_W + 1;
  localparam logic [ACC_W-1:0] ONE_FX = ACC_W'(1) << FRAC_W;

  // ---- arithmetic helpers ----
  function automatic logic [ADDR_W-1:0] calc_addr(
    input logic [WORD_W-1:0] x, input logic [WORD_W-1:0] y,
    input logic [WB_W-1:0] wb, input logic [WORD_W-1:0] off, input logic m400);
    logic [31:0] full;
    full = 32'(y) * 32'(wb) + 32'(x >> 3) + (32'(off) << 1);
    return m400 ? full[ADDR_W-1:0] : {1'b0, full[ADDR_W-2:0]};
  endfunction

  function automatic logic [BYTE_W-1:0] pix_bit(input logic [2:0] p);
    return 8'h80 >> p;
  endfunction

  function automatic logic [DIFF_W-1:0] span(input logic [WORD_W-1:0] a,
                                             input logic [WORD_W-1:0] b);
    logic [DIFF_W-1:0] d;
    d = {b[WORD_W-1], b} - {a[WORD_W-1], a};
    return d[DIFF_W-1] ? (~d + 1'b1) : d;
  endfunction

  function automatic logic lt_s(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  // ---- registers ----
  logic [WORD_W-1:0] rw [NREG];
  logic [WORD_W-1:0] r_off, r_pat, r_xs, r_ys, r_xe, r_ye;
  logic              pat_upd;
  logic [WORD_W-1:0] pat_new;

  lwe_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .lock(busy), .pat_upd(pat_upd), .pat_new(pat_new), .words(rw)
  );

  assign r_off = rw[IDX_OFF];
  assign r_pat = rw[IDX_PAT];
  assign r_xs  = rw[IDX_XS];
  assign r_ys  = rw[IDX_YS];
  assign r_xe  = rw[IDX_XE];
  assign r_ye  = rw[IDX_YE];

  // ---- walk state ----
  lwe_state_e        st;
  logic              x_major, maj_dn, min_dn;
  logic [WORD_W-1:0] maj_cur, min_cur, min_end;
  logic [DIFF_W-1:0] steps_left;
  logic [NUM_W-1:0]  diff;
  logic [ACC_W-1:0]  acc;
  logic [BYTE_W-1:0] wmask;
  logic [ADDR_W-1:0] prev_addr;
  logic              have_prev;
  logic [CNT_W-1:0]  nbytes;
  logic              op_valid_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [BYTE_W-1:0] op_mask_q;
  logic              hold_active;

  // ---- launch decode ----
  logic [DIFF_W-1:0] dx_len, dy_len, maj_len, min_len;
  logic              go_x, launch, div_go, div_done;
  logic [NUM_W-1:0]  div_quo, div_num;

  assign dx_len  = span(r_xs, r_xe);
  assign dy_len  = span(r_ys, r_ye);
  assign go_x    = dx_len >= dy_len;
  assign maj_len = go_x ? dx_len : dy_len;
  assign min_len = go_x ? dy_len : dx_len;
  assign launch  = (st == ST_IDLE) && start && !hold_active;
  assign div_go  = launch && (maj_len != '0);
  assign div_num = {min_len + 1'b1, {FRAC_W{1'b0}}};

  lwe_div #(.NUM_W(NUM_W), .DEN_W(WORD_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num),
    .den(maj_len[WORD_W-1:0]), .done(div_done), .quo(div_quo)
  );

  // ---- per-dot events ----
  logic [WORD_W-1:0] dot_x, dot_y;
  logic              dot_vis, dot_fire, byte_change, adv, at_end;
  logic [ADDR_W-1:0] dot_addr;
  logic [BYTE_W-1:0] dot_clr;
  logic [ACC_W-1:0]  acc_sum;

  assign dot_x    = x_major ? maj_cur : min_cur;
  assign dot_y    = x_major ? min_cur : maj_cur;
  assign dot_vis  = draw_en && !dot_x[WORD_W-1] && !dot_y[WORD_W-1]
                    && (dot_x < WORD_W'({scr_wbytes, 3'b000}))
                    && (dot_y < scr_height);
  assign dot_fire = (st == ST_DOT) && dot_vis;
  assign dot_addr = calc_addr(dot_x, dot_y, scr_wbytes, r_off, mode400);
  assign dot_clr  = r_pat[WORD_W-1] ? pix_bit(dot_x[2:0]) : '0;
  assign byte_change = dot_fire && have_prev && (dot_addr != prev_addr);
  assign at_end   = (steps_left == '0);
  assign adv      = (((st == ST_DOT) && !byte_change) || ((st == ST_WAIT) && op_ready))
                    && !at_end;
  assign acc_sum  = acc + ACC_W'(diff);
  assign pat_upd  = dot_fire;
  assign pat_new  = {r_pat[WORD_W-2:0], r_pat[WORD_W-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      x_major    <= 1'b0;
      maj_dn     <= 1'b0;
      min_dn     <= 1'b0;
      maj_cur    <= '0;
      min_cur    <= '0;
      min_end    <= '0;
      steps_left <= '0;
      diff       <= '0;
      acc        <= '0;
      wmask      <= '1;
      prev_addr  <= '0;
      have_prev  <= 1'b0;
      nbytes     <= '0;
      op_valid_q <= 1'b0;
      op_addr_q  <= '0;
      op_mask_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (launch) begin
          x_major    <= go_x;
          maj_cur    <= go_x ? r_xs : r_ys;
          min_cur    <= go_x ? r_ys : r_xs;
          min_end    <= go_x ? r_ye : r_xe;
          maj_dn     <= go_x ? lt_s(r_xe, r_xs) : lt_s(r_ye, r_ys);
          min_dn     <= go_x ? lt_s(r_ye, r_ys) : lt_s(r_xe, r_xs);
          steps_left <= maj_len;
          acc        <= '0;
          diff       <= '0;
          wmask      <= '1;
          have_prev  <= 1'b0;
          nbytes     <= '0;
          st         <= (maj_len == '0) ? ST_DOT : ST_DIV;
        end
        ST_DIV: if (div_done) begin
          diff <= div_quo;
          st   <= ST_DOT;
        end
        ST_DOT: begin
          if (dot_fire) begin
            prev_addr <= dot_addr;
            have_prev <= 1'b1;
          end
          if (byte_change) begin
            op_valid_q <= 1'b1;
            op_addr_q  <= prev_addr;
            op_mask_q  <= wmask;
            wmask      <= ~dot_clr;
            nbytes     <= nbytes + 1'b1;
            st         <= ST_WAIT;
          end else begin
            if (dot_fire) wmask <= wmask & ~dot_clr;
            if (at_end) st <= ST_LAST;
          end
        end
        ST_WAIT: if (op_ready) begin
          op_valid_q <= 1'b0;
          st         <= at_end ? ST_LAST : ST_DOT;
        end
        ST_LAST: begin
          if (have_prev) begin
            op_valid_q <= 1'b1;
            op_addr_q  <= prev_addr;
            op_mask_q  <= wmask;
            nbytes     <= nbytes + 1'b1;
            st         <= ST_WLAST;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_WLAST: if (op_ready) begin
          op_valid_q <= 1'b0;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase

      if (adv) begin
        steps_left <= steps_left - 1'b1;
        maj_cur    <= maj_dn ? maj_cur - 1'b1 : maj_cur + 1'b1;
        if (acc_sum >= ONE_FX) begin
          acc <= acc_sum - ONE_FX;
          if (min_cur != min_end) min_cur <= min_dn ? min_cur - 1'b1 : min_cur + 1'b1;
        end else begin
          acc <= acc_sum;
        end
      end
    end
  end

  // ---- busy hold after long bursts ----
  logic             hold_load;
  logic [CNT_W-1:0] hold_val;
  logic [31:0]      hold_full;

  assign hold_full = (32'(nbytes) * 32'(CYC_PER_US)) >> 4;
  assign hold_val  = hold_full[CNT_W-1:0];
  assign hold_load = (st == ST_WLAST) && op_ready && (nbytes > CNT_W'(BURST_LIM));

  lwe_hold #(.CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(hold_load), .val(hold_val), .active(hold_active)
  );

  assign busy     = (st != ST_IDLE) || hold_active;
  assign op_valid = op_valid_q;
  assign op_addr  = op_addr_q;
  assign op_mask  = op_mask_q;
endmodule

// File: rtl/lwe_chk.sv
module lwe_chk #(
  parameter int ADDR_W = 15,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              op_valid,
  input logic              op_ready,
  input logic [ADDR_W-1:0] op_addr,
  input logic [7:0]        op_mask,
  input logic              mode400,
  input logic              dot_fire,
  input logic              byte_change,
  input logic [ADDR_W-1:0] prev_addr,
  input logic [WORD_W-1:0] pat_cur,
  input logic              hold_load
);
  // R9
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_addr) && $stable(op_mask));

  // R9
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> busy);

  // R2
  short_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !mode400 |-> !op_addr[ADDR_W-1]);

  // R4
  pat_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dot_fire |=> pat_cur == {$past(pat_cur[WORD_W-2:0]), $past(pat_cur[WORD_W-1])});

  // R5
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_change |=> op_valid && (op_addr == $past(prev_addr)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_load |=> busy && !op_valid);
endmodule

bind line_walk_engine lwe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .op_valid(op_valid), .op_ready(op_ready),
  .op_addr(op_addr), .op_mask(op_mask), .mode400(mode400), .dot_fire(dot_fire),
  .byte_change(byte_change), .prev_addr(prev_addr), .pat_cur(r_pat),
  .hold_load(hold_load)
);

// File: tb/test_line_walk_engine.sv
module test_line_walk_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        start = 1'b0;
  logic        draw_en = 1'b1;
  logic        mode400 = 1'b1;
  logic [7:0]  scr_wbytes = 8'd8;
  logic [15:0] scr_height = 16'd32;
  logic        busy, op_valid, op_ready = 1'b0;
  logic [14:0] op_addr;
  logic [7:0]  op_mask;

  line_walk_engine i_line_walk_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .draw_en(draw_en), .mode400(mode400), .scr_wbytes(scr_wbytes),
    .scr_height(scr_height), .busy(busy), .op_valid(op_valid), .op_addr(op_addr),
    .op_mask(op_mask), .op_ready(op_ready)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int ready_pct = 100;
  int qa[$], qm[$];
  string cur_tag = "R10";
  bit tail_on = 0;
  int tail_cnt = 0;
  logic [15:0] m_w [6];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // handshake monitor: drive op_ready, record accepted requests
  always @(negedge clk) begin
    if (tail_on) begin
      if (busy) tail_cnt++;
      else tail_on = 0;
    end
    op_ready = ($urandom_range(99) < ready_pct);
    if (rst_n && op_valid && op_ready) begin
      if (qa.size() == 0) begin
        chk(0, {cur_tag, " R5 unexpected request"}, op_addr, -1);
      end else begin
        chk(op_addr == qa[0][14:0], {cur_tag, " R2 R5 addr"}, op_addr, qa[0]);
        chk(op_mask == qm[0][7:0], {cur_tag, " R4 R5 mask"}, op_mask, qm[0]);
        void'(qa.pop_front());
        void'(qm.pop_front());
        if (qa.size() == 0) begin tail_on = 1; tail_cnt = 0; end
      end
    end
  end

  task automatic wr_byte(input int sel, input int data);
    @(negedge clk);
    wr_en = 1; wr_sel = 4'(sel); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_word(input int idx, input int val);
    wr_byte(2 * idx, (val >> 8) & 255);
    wr_byte(2 * idx + 1, val & 255);
    m_w[idx] = 16'(val);
  endtask

  // reference walk built from the requirements
  function automatic int predict();
    int xs, ys, xe, ye, ax, ay, sx, sy, nmaj, nmin, diff, acc, mo, x, y, a, prev, nb;
    bit xmaj, have;
    int mask;
    xs = int'($signed(m_w[2])); ys = int'($signed(m_w[3]));
    xe = int'($signed(m_w[4])); ye = int'($signed(m_w[5]));
    ax = xe - xs; ay = ye - ys;
    sx = (ax < 0) ? -1 : 1; sy = (ay < 0) ? -1 : 1;
    if (ax < 0) ax = -ax;
    if (ay < 0) ay = -ay;
    xmaj = (ax >= ay);
    nmaj = xmaj ? ax : ay; nmin = xmaj ? ay : ax;
    diff = (nmaj == 0) ? 0 : ((nmin + 1) * 1024) / nmaj;
    acc = 0; mo = 0; have = 0; mask = 255; prev = 0; nb = 0;
    for (int k = 0; k <= nmaj; k++) begin
      x = xmaj ? xs + sx * k : xs + sx * mo;
      y = xmaj ? ys + sy * mo : ys + sy * k;
      if (draw_en && x >= 0 && y >= 0 && x < 8 * int'(scr_wbytes) && y < int'(scr_height)) begin
        a = (y * int'(scr_wbytes) + x / 8 + 2 * int'(m_w[0])) & (mode400 ? 32'h7fff : 32'h3fff);
        if (have && a != prev) begin
          qa.push_back(prev); qm.push_back(mask); nb++; mask = 255;
        end
        if (m_w[1][15]) mask = mask & ~(8'h80 >> (x & 7));
        m_w[1] = {m_w[1][14:0], m_w[1][15]};
        prev = a; have = 1;
      end
      acc += diff;
      if (acc >= 1024) begin
        acc -= 1024;
        if (mo < nmin) mo++;
      end
    end
    if (have) begin qa.push_back(prev); qm.push_back(mask); nb++; end
    return nb;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic finish_line(input string tag, input int nb);
    int guard = 0;
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    chk(qa.size() == 0, {tag, " R6 pending bytes"}, qa.size(), 0);
    if (nb > 0) chk(tail_cnt == ((nb > 8) ? nb : 0), {tag, " R8 hold cycles"}, tail_cnt,
                    (nb > 8) ? nb : 0);
    qa.delete(); qm.delete(); tail_on = 0; tail_cnt = 0;
  endtask

  task automatic run_line(input string tag, input int x0, input int y0, input int x1, input int y1);
    int nb;
    set_word(2, x0); set_word(3, y0); set_word(4, x1); set_word(5, y1);
    cur_tag = tag;
    nb = predict();
    pulse_start();
    finish_line(tag, nb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int nb;
    void'($urandom(32'd4711));
    for (int i = 0; i < 6; i++) m_w[i] = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R10 busy in reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && op_valid == 0, "R10 idle after reset", {busy, op_valid}, 0);
    // R10: zero registers give one dot at origin, address 0, mask FF
    cur_tag = "R10 zero regs";
    nb = predict();
    pulse_start();
    finish_line("R10 zero regs", nb);

    // R7 zero length, pattern MSB set: dot x=5 -> mask FB
    set_word(1, 16'h8000);
    set_word(0, 0);
    run_line("R7 single dot", 5, 3, 5, 3);
    // R4 continued dash across lines
    ready_pct = 60;
    run_line("R4 dash carry a", 0, 1, 10, 1);
    run_line("R4 dash carry b", 11, 1, 30, 1);
    // R8 boundary: 8 bytes no hold, then 9 bytes with hold
    set_word(1, 16'hffff);
    run_line("R8 eight bytes", 0, 2, 63, 2);
    scr_wbytes = 8'd10;
    run_line("R8 nine bytes", 0, 2, 71, 2);
    // R7 steep and reversed
    run_line("R7 steep", 20, 30, 14, 0);
    run_line("R7 reversed", 70, 20, 3, 9);
    // R3 clipping and disable
    run_line("R3 offscreen", -30, -5, -2, -9);
    run_line("R3 clip edges", -9, -4, 90, 40);
    draw_en = 0;
    run_line("R3 draw off", 0, 0, 40, 10);
    draw_en = 1;
    // R2 address wrap in short mode
    mode400 = 0;
    set_word(0, 16'h3fff);
    run_line("R2 wrap short", 0, 5, 50, 12);
    mode400 = 1;
    run_line("R2 wide mode", 0, 5, 50, 12);
    set_word(0, 0);
    // R1 writes and start ignored while busy
    set_word(2, 0); set_word(3, 0); set_word(4, 60); set_word(5, 4);
    cur_tag = "R1 lock";
    ready_pct = 30;
    nb = predict();
    pulse_start();
    wr_byte(5, 33);
    wr_byte(9, 2);
    pulse_start();
    finish_line("R1 lock", nb);
    wr_byte(12, 99);
    cur_tag = "R1 kept regs";
    nb = predict();
    pulse_start();
    finish_line("R1 kept regs", nb);

    // random lines
    for (int n = 0; n < 120; n++) begin
      int wb, h;
      wb = 3 + $urandom_range(9);
      h = 8 + $urandom_range(40);
      scr_wbytes = 8'(wb);
      scr_height = 16'(h);
      mode400 = $urandom_range(1);
      draw_en = ($urandom_range(9) != 0);
      ready_pct = 30 + $urandom_range(70);
      if ($urandom_range(3) == 0) set_word(1, $urandom_range(65535));
      if ($urandom_range(3) == 0) set_word(0, $urandom_range(16'h7fff));
      run_line("R7 random", $urandom_range(8 * wb + 40) - 20, $urandom_range(h + 20) - 10,
               $urandom_range(8 * wb + 40) - 20, $urandom_range(h + 20) - 10);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule